// File: doc/BRIEF.md
# Zero-Region Instruction Skip Unit

This unit sits beside a processor pipeline. It lets the core jump over a run of instructions when their result is already known to be zero because the registers they read hold zero. It keeps one zero flag per architectural register and refreshes that flag whenever a writeback completes. It also holds a small fully associative table of skippable regions. Each table entry is keyed on the PC of the instruction that comes just before its region.

Every fetch PC is compared against the table. On a hit, the unit checks the entry's register mask against the zero flags. If every named register is known to be zero, the next PC is moved past the region. If not, fetch continues in program order. Two conditions block a skip. The first is an early decode hint that marks a branch or jump: control flow always wins. The second is any write to a masked register that is still in flight, because its flag may be stale.

Software fills the table through a small register port. A configuration word at offset 0x04 selects the entry and the field to write. A data word at offset 0x00 then writes that field.

Top module: `zskip_unit`

## Requirements
- R1: After reset, all table entries are invalid and the flags of registers 1 to 31 are clear. With no other stimulus, `skip_taken` is 0 and `next_pc` equals `fetch_pc + 4`.
- R2: The flag of register 0 always reads as zero-valued. A writeback to register 0 with any data changes no flag, so a region whose mask names only register 0 is always skippable.
- R3: A writeback with `wb_valid=1` to register r≠0 sets r's flag if `wb_data` is 0 and clears it otherwise. The new flag is used from the next cycle on.
- R4: A write to offset 0x04 latches the entry index from bits [2:0] and the field select from bits [5:4]. The field select is 0 for the key PC, 1 for the register mask and 2 for the count/valid word. When bit 31 of that write is 1, it also invalidates every entry, effective from the next cycle.
- R5: A write to offset 0x00 stores `cfg_wdata` into the selected field of the selected entry, effective from the next cycle. For the mask, bit n names register n. For the count/valid word, bits [7:0] are the skip count and bit 31 is the valid bit. Field select 3 stores nothing.
- R6: When `fetch_pc` matches a valid entry, every masked register is flagged zero and nothing blocks the skip, `skip_taken` is 1 and `next_pc = fetch_pc + 4*(count+1)`. These outputs are combinational in the current cycle.
- R7: On a hit where any masked register's flag is clear, `skip_taken` is 0 and `next_pc = fetch_pc + 4`.
- R8: While `dec_ctrl_flow` is 1, no skip is taken.
- R9: No skip is taken while a masked register other than register 0 has its `inflight` bit set, or is being written back in the same cycle.
- R10: When several valid entries match the same PC, the one with the lowest index decides the outcome.
- R11: Configuration writes to any offset other than 0x00 and 0x04 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wb_valid | input | 1 | A register writeback completes this cycle |
| wb_rd | input | 5 | Destination register of the writeback |
| wb_data | input | 32 | Value written back |
| inflight | input | 32 | Bit n set: a write to register n is issued but not yet written back |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Byte offset of the configuration write |
| cfg_wdata | input | 32 | Configuration write data |
| fetch_pc | input | 32 | PC of the instruction being fetched |
| dec_ctrl_flow | input | 1 | Early decode hint: a branch or jump is in decode |
| skip_taken | output | 1 | The region following `fetch_pc` is skipped |
| next_pc | output | 32 | PC to fetch next |

## Verification
The hardest case to reach is a skip that must be blocked because a condition register's flag is about to change. This happens either when a masked register has an in-flight write, or when its writeback lands in the same cycle as the matching fetch. The stimulus reaches it directly: it first makes a region skippable, then fetches its key PC while the masked register is written back with non-zero data. In the following cycle the same fetch must also refuse the skip. A long random phase then mixes table writes, clears, writebacks, in-flight bits and decode hints over a few key PCs. A behavioural model follows the flags and table contents and predicts the outputs on every cycle.

// File: rtl/zskip_pkg.sv
// Shared constants and types for the zero-region skip unit.
package zskip_pkg;
    localparam int XLEN    = 32;
    localparam int NREG    = 32;
    localparam int RIDX_W  = $clog2(NREG);
    localparam int CNT_W   = 8;
    localparam int CFG_AW  = 8;

    // Field selected by the configuration word, bits [5:4]
    typedef enum logic [1:0] {
        FLD_KEY  = 2'd0,
        FLD_MASK = 2'd1,
        FLD_CTRL = 2'd2,
        FLD_NONE = 2'd3
    } fld_e;

    typedef struct packed {
        logic             valid;
        logic [CNT_W-1:0] cnt;
        logic [NREG-1:0]  mask;
        logic [XLEN-1:0]  key;
    } region_t;
endpackage

// File: rtl/zskip_zero_flags.sv
// Per-register zero flags. Assumes register 0 is hardwired zero; other
// flags reset to "unknown/non-zero" so nothing is skipped before software
// values are known. Updated on writeback, visible the next cycle.
module zskip_zero_flags
    import zskip_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wb_valid,
    input  logic [RIDX_W-1:0] wb_rd,
    input  logic [XLEN-1:0]   wb_data,
    output logic [NREG-1:0]   flags
);
    logic [NREG-1:1] flag_q;

    // Record whether each written register now holds zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else if (wb_valid && wb_rd != '0) begin
            flag_q[wb_rd] <= (wb_data == '0);
        end
    end

    assign flags = {flag_q, 1'b1};

    AST_WB_UPDATES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && wb_rd != '0) |=> (flags[$past(wb_rd)] == ($past(wb_data) == '0))); // R3
    AST_X0_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && wb_rd == '0) |=> (flags == $past(flags))); // R2
endmodule

// File: rtl/zskip_region_table.sv
// Fully associative table of skippable regions, loaded by a select word at
// CFG_OFF and a data word at DATA_OFF. Lookup is combinational against
// fetch_pc; the lowest matching index wins.
module zskip_region_table
    import zskip_pkg::*;
#(
    parameter int NENT     = 8,
    parameter int CFG_OFF  = 4,
    parameter int DATA_OFF = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [XLEN-1:0]   cfg_wdata,
    input  logic [XLEN-1:0]   fetch_pc,
    output logic              hit,
    output logic [NREG-1:0]   hit_mask,
    output logic [CNT_W-1:0]  hit_cnt
);
    localparam int IDX_W = $clog2(NENT);

    region_t          tbl [NENT];
    logic [IDX_W-1:0] sel_idx;
    fld_e             sel_fld;
    logic [NENT-1:0]  match;
    logic             wr_cfg, wr_data;

    assign wr_cfg  = cfg_wr && (cfg_addr == CFG_AW'(CFG_OFF));
    assign wr_data = cfg_wr && (cfg_addr == CFG_AW'(DATA_OFF));

    // Latch the entry index and field selected by software
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_idx <= '0;
            sel_fld <= FLD_KEY;
        end else if (wr_cfg) begin
            sel_idx <= cfg_wdata[IDX_W-1:0];
            sel_fld <= fld_e'(cfg_wdata[5:4]);
        end
    end

    generate
        for (genvar i = 0; i < NENT; i++) begin : g_ent
            // Store the selected field, or invalidate on a clear-all word
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    tbl[i] <= '0;
                end else if (wr_cfg && cfg_wdata[XLEN-1]) begin
                    tbl[i].valid <= 1'b0;
                end else if (wr_data && sel_idx == IDX_W'(i)) begin
                    case (sel_fld)
                        FLD_KEY:  tbl[i].key  <= cfg_wdata;
                        FLD_MASK: tbl[i].mask <= cfg_wdata[NREG-1:0];
                        FLD_CTRL: begin
                            tbl[i].cnt   <= cfg_wdata[CNT_W-1:0];
                            tbl[i].valid <= cfg_wdata[XLEN-1];
                        end
                        default: ;
                    endcase
                end
            end
            assign match[i] = tbl[i].valid && (tbl[i].key == fetch_pc);
        end
    endgenerate

    // Priority pick: lowest matching index supplies mask and count
    always_comb begin
        hit      = 1'b0;
        hit_mask = '0;
        hit_cnt  = '0;
        for (int i = NENT - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit      = 1'b1;
                hit_mask = tbl[i].mask;
                hit_cnt  = tbl[i].cnt;
            end
        end
    end

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cfg && cfg_wdata[XLEN-1]) |=> (match == '0)); // R4
    AST_ODD_OFFSET_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !wr_cfg && !wr_data) |=> (sel_idx == $past(sel_idx) && sel_fld == $past(sel_fld))); // R11
endmodule

// File: rtl/zskip_unit.sv
// Top of the skip unit: combines the zero flags, the region table, the
// decode-stage control-flow hint and pending-write tracking into a next-PC
// decision. Assumes fixed 4-byte instructions.
module zskip_unit
    import zskip_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wb_valid,
    input  logic [RIDX_W-1:0] wb_rd,
    input  logic [XLEN-1:0]   wb_data,
    input  logic [NREG-1:0]   inflight,
    input  logic              cfg_wr,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [XLEN-1:0]   cfg_wdata,
    input  logic [XLEN-1:0]   fetch_pc,
    input  logic              dec_ctrl_flow,
    output logic              skip_taken,
    output logic [XLEN-1:0]   next_pc
);
    logic [NREG-1:0]  flags;
    logic             hit;
    logic [NREG-1:0]  hit_mask;
    logic [CNT_W-1:0] hit_cnt;
    logic [NREG-1:0]  pending;
    logic             cond_zero, stale;

    zskip_zero_flags u_flags (
        .clk(clk), .rst_n(rst_n), .wb_valid(wb_valid), .wb_rd(wb_rd),
        .wb_data(wb_data), .flags(flags)
    );

    zskip_region_table #(.NENT(8), .CFG_OFF(4), .DATA_OFF(0)) u_table (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .fetch_pc(fetch_pc), .hit(hit),
        .hit_mask(hit_mask), .hit_cnt(hit_cnt)
    );

    // Registers whose flag is about to change: in flight or written now
    always_comb begin
        pending = inflight & ~NREG'(1);
        if (wb_valid && wb_rd != '0) pending[wb_rd] = 1'b1;
    end

    // Skip decision and next-PC selection
    always_comb begin
        cond_zero  = ((hit_mask & ~flags) == '0);
        stale      = ((hit_mask & pending) != '0);
        skip_taken = hit && cond_zero && !stale && !dec_ctrl_flow;
        next_pc    = skip_taken ? fetch_pc + ((XLEN'(hit_cnt) + XLEN'(1)) << 2)
                                : fetch_pc + XLEN'(4);
    end

    AST_CTRL_FLOW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        dec_ctrl_flow |-> !skip_taken); // R8
    AST_NO_STALE_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        ((hit_mask & pending) != '0) |-> !skip_taken); // R9
    AST_SKIP_NEEDS_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
        skip_taken |-> (hit && ((hit_mask & ~flags) == '0))); // R6
    AST_SEQ_WHEN_NO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        !skip_taken |-> (next_pc == fetch_pc + XLEN'(4))); // R7
endmodule

// File: tb/tb_zskip_unit.sv
module tb_zskip_unit;
    localparam int PERIOD = 10;

    logic        clk = 0, rst_n = 0;
    logic        wb_valid = 0;
    logic [4:0]  wb_rd = 0;
    logic [31:0] wb_data = 0, inflight = 0, cfg_wdata = 0, fetch_pc = 0;
    logic        cfg_wr = 0, dec_ctrl_flow = 0;
    logic [7:0]  cfg_addr = 0;
    logic        skip_taken;
    logic [31:0] next_pc;

    int total = 0, bad = 0;
    bit done = 0;

    // Behavioural model state
    logic [31:0] m_key [8];
    logic [31:0] m_mask [8];
    logic [7:0]  m_cnt [8];
    bit          m_val [8];
    logic [31:0] m_flag = 32'h1;
    int          m_idx = 0, m_fld = 0;

    always #(PERIOD/2) clk = ~clk;

    zskip_unit dut (
        .clk(clk), .rst_n(rst_n), .wb_valid(wb_valid), .wb_rd(wb_rd),
        .wb_data(wb_data), .inflight(inflight), .cfg_wr(cfg_wr),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .fetch_pc(fetch_pc),
        .dec_ctrl_flow(dec_ctrl_flow), .skip_taken(skip_taken), .next_pc(next_pc)
    );

    task automatic cyc(input logic wv, input logic [4:0] wr, input logic [31:0] wd,
                       input logic [31:0] inf, input logic cw, input logic [7:0] ca,
                       input logic [31:0] cd, input logic [31:0] pc, input logic ct,
                       input string tag);
        int hit_i;
        bit e_skip, stale;
        logic [31:0] e_pc, pend;
        string t;
        @(negedge clk);
        wb_valid = wv; wb_rd = wr; wb_data = wd; inflight = inf;
        cfg_wr = cw; cfg_addr = ca; cfg_wdata = cd; fetch_pc = pc; dec_ctrl_flow = ct;
        #1;
        hit_i = -1;
        for (int i = 7; i >= 0; i--) if (m_val[i] && m_key[i] == pc) hit_i = i;
        pend = inf & ~32'h1;
        if (wv && wr != 0) pend[wr] = 1'b1;
        e_skip = 0; e_pc = pc + 4; t = "R5";
        if (hit_i >= 0) begin
            stale = (m_mask[hit_i] & pend) != 0;
            if (ct) t = "R8";
            else if (stale) t = "R9";
            else if ((m_mask[hit_i] & ~m_flag) != 0) t = "R7";
            else begin
                t = "R6"; e_skip = 1;
                e_pc = pc + 4 * (32'(m_cnt[hit_i]) + 1);
            end
        end
        if (tag != "") t = tag;
        total++;
        if (skip_taken !== e_skip || next_pc !== e_pc) begin
            bad++;
            $display("FAIL %s: skip=%0d next_pc=%h expected skip=%0d next_pc=%h",
                     t, skip_taken, next_pc, e_skip, e_pc);
        end
        // Model update for the coming clock edge
        if (cw && ca == 8'h04) begin
            if (cd[31]) for (int i = 0; i < 8; i++) m_val[i] = 0;
            m_idx = int'(cd[2:0]); m_fld = int'(cd[5:4]);
        end else if (cw && ca == 8'h00) begin
            case (m_fld)
                0: m_key[m_idx] = cd;
                1: m_mask[m_idx] = cd;
                2: begin m_cnt[m_idx] = cd[7:0]; m_val[m_idx] = cd[31]; end
                default: ;
            endcase
        end
        if (wv && wr != 0) m_flag[wr] = (wd == 0);
    endtask

    task automatic idle(input logic [31:0] pc, input logic ct, input logic [31:0] inf, input string tag);
        cyc(0, 0, 0, inf, 0, 0, 0, pc, ct, tag);
    endtask

    task automatic cfgw(input logic [7:0] a, input logic [31:0] d, input string tag);
        cyc(0, 0, 0, 0, 1, a, d, 32'h0, 0, tag);
    endtask

    task automatic wb(input logic [4:0] r, input logic [31:0] d, input string tag);
        cyc(1, r, d, 0, 0, 0, 0, 32'h0, 0, tag);
    endtask

    task automatic load(input int idx, input logic [31:0] key, input logic [31:0] mask,
                        input logic [7:0] cnt);
        cfgw(8'h04, 32'(idx), "R4");
        cfgw(8'h00, key, "R5");
        cfgw(8'h04, 32'(idx) | 32'h10, "R4");
        cfgw(8'h00, mask, "R5");
        cfgw(8'h04, 32'(idx) | 32'h20, "R4");
        cfgw(8'h00, 32'h8000_0000 | 32'(cnt), "R5");
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) begin m_val[i] = 0; m_key[i] = 0; m_mask[i] = 0; m_cnt[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        idle(32'h100, 0, 0, "R1");                 // R1 reset: no skip
        load(0, 32'h100, 32'h60, 8'd3);            // entry 0: x5,x6 count 3
        idle(32'h100, 0, 0, "R7");                 // R7 flags still clear
        wb(5, 0, "R3"); wb(6, 0, "R3");
        idle(32'h100, 0, 0, "R6");                 // R6 skip to 0x110
        idle(32'h104, 0, 0, "R5");                 // no key match
        idle(32'h100, 1, 0, "R8");                 // R8 control flow wins
        idle(32'h100, 0, 32'h20, "R9");            // R9 x5 in flight
        idle(32'h100, 0, 32'h1, "R2");             // x0 in flight is harmless
        cyc(1, 6, 32'h7, 0, 0, 0, 0, 32'h100, 0, "R9"); // R9 same-cycle writeback
        idle(32'h100, 0, 0, "R3");                 // R3 x6 now non-zero
        wb(6, 0, "R3");
        wb(0, 32'h5, "R2");                        // R2 x0 write ignored
        load(1, 32'h200, 32'h1, 8'd0);
        idle(32'h200, 0, 0, "R2");                 // R2 x0-only mask skips
        load(2, 32'h100, 32'h80, 8'd9);            // same key, x7 not zero
        idle(32'h100, 0, 0, "R10");                // R10 entry 0 wins: 0x110
        cfgw(8'h08, 32'h8000_0000, "R11");         // R11 odd offset
        cfgw(8'h0C, 32'h0, "R11");
        idle(32'h100, 0, 0, "R11");                // still skips
        cfgw(8'h04, 32'h8000_0000, "R4");          // R4 clear all
        idle(32'h100, 0, 0, "R4");
        idle(32'h200, 0, 0, "R4");
        // Random phase
        for (int n = 0; n < 3000; n++) begin
            int k;
            logic [31:0] keys [4];
            keys[0] = 32'h100; keys[1] = 32'h104; keys[2] = 32'h200; keys[3] = 32'h300;
            k = $urandom_range(0, 19);
            if (k == 0)
                cyc(0, 0, 0, 0, 1, 8'h04,
                    ($urandom_range(0, 15) == 0 ? 32'h8000_0000 : 32'h0) |
                    32'($urandom_range(0, 7)) | (32'($urandom_range(0, 3)) << 4),
                    keys[$urandom_range(0, 3)], 0, "");
            else if (k == 1) begin
                logic [31:0] d;
                case ($urandom_range(0, 2))
                    0: d = keys[$urandom_range(0, 3)];
                    1: d = 32'(1) << $urandom_range(0, 7) | 32'(1) << $urandom_range(0, 7);
                    default: d = {1'b1, 23'h0, 8'($urandom_range(0, 255))};
                endcase
                cyc(0, 0, 0, 0, 1, 8'h00, d, keys[$urandom_range(0, 3)], 0, "");
            end else begin
                logic wv;
                logic [31:0] inf;
                wv = ($urandom_range(0, 2) == 0);
                inf = ($urandom_range(0, 5) == 0) ? (32'(1) << $urandom_range(0, 7)) : 32'h0;
                cyc(wv, 5'($urandom_range(0, 7)), ($urandom_range(0, 1) == 0) ? 32'h0 : 32'($urandom),
                    inf, 0, 0, 0, keys[$urandom_range(0, 3)], ($urandom_range(0, 7) == 0), "");
            end
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule